// File: doc/BRIEF.md
# Per-Core Heartbeat NMI Watchdog

This block watches a set of processor cores for starvation of their periodic timer interrupt. Each core has its own counter that advances on a shared prescaled time tick. The counter goes back to zero only when that core actually services its local timer interrupt, which means a heartbeat pulse while the core's maskable-interrupt enable flag is set. A core that goes the configured number of ticks without a serviced heartbeat gets a non-maskable interrupt request. The request ignores the enable flag, so a core that spins with interrupts turned off is still caught.

Software reaches the block through a small write-only register bus. One register switches the whole function on or off at run time. A second register clears the sticky per-core record of fired requests, one bit per core, by writing 1 to that bit. Each core drops its own request with an acknowledge line, and the acknowledge also restarts that core's count.

Top module: `hb_nmi_watchdog`

## Requirements
- R1: After reset every request line and every status bit is 0, and the function is on (enable = 1).
- R2: While enabled, a core whose counter receives TIMEOUT ticks with no restart raises its request line on the clock edge that samples the TIMEOUT-th tick. It does not raise it one tick earlier.
- R3: A heartbeat that arrives while the core's interrupt enable is 1 restarts that core's count from zero. A heartbeat that arrives while the enable is 0 is not serviced and does not change the count.
- R4: The request line is raised whatever the value of the core's interrupt enable input.
- R5: A raised request line stays at 1 until that core's acknowledge is sampled high. It is 0 on the next edge. The acknowledge also restarts the count, so the next request needs a further TIMEOUT ticks.
- R6: A bus write to address 0 loads bit 0 of the write data into the enable register. While the enable is 0, all counters are held at zero and no request line rises. A request that is already pending stays until it is acknowledged.
- R7: After the enable is written back to 1, counting starts from zero. With a tick on every cycle, the first request comes exactly TIMEOUT edges after the edge that samples the write.
- R8: A core's status bit goes to 1 on the edge where its request rises, and it stays at 1 after the acknowledge. A bus write to address 1 clears each status bit whose data bit is 1 and leaves the others unchanged. If a clear and a new request meet in one cycle, the new request wins.
- R9: Cores that expire in the same cycle raise their request lines on the same edge, with no arbitration between them.
- R10: The heartbeat, enable flag and acknowledge of one core have no effect on any other core's count or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled time tick, one cycle wide |
| hb_i | input | N_CORES | Timer-interrupt heartbeat pulse per core |
| ie_i | input | N_CORES | Maskable-interrupt enable flag per core |
| nmi_ack_i | input | N_CORES | Request acknowledge per core |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 enable, 1 status clear |
| bus_wdata_i | input | DATA_W | Register write data |
| nmi_req_o | output | N_CORES | Non-maskable interrupt request per core |
| status_o | output | N_CORES | Sticky per-core fired record |

## Verification
The bench builds the block with four cores and a TIMEOUT of 8 ticks instead of the seconds-long default. With that setting expiry, acknowledge, disable and re-enable all happen within a few dozen cycles, so thousands of random cycles can push every core through many full timeout periods. Four cores are enough to show simultaneous expiry and to show that one core's heartbeat leaves the others alone. The 3-bit counter hits its final value often, so the exact tick on which the request rises is checked again and again.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    WDG_REG_CTRL  = 2'd0,
    WDG_REG_STCLR = 2'd1
  } wdg_reg_e;
endpackage

// File: rtl/wdg_core_timer.sv
module wdg_core_timer #(
  parameter int TIMEOUT = 5000,
  localparam int CNT_W  = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic hb,
  input  logic ie,
  input  logic ack,
  output logic req,
  output logic fire
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             restart;
  logic             at_last;

  // A heartbeat counts only if the core could service it.
  assign restart = (hb & ie) | ack;
  assign at_last = (cnt_q == CNT_LAST);
  assign fire    = en & ~restart & tick & ~req_q & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (!en || restart) begin
      cnt_d = '0;
    end else if (tick && !req_q) begin
      cnt_d = at_last ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    req_d = req_q;
    if (ack) begin
      req_d = 1'b0;
    end else if (fire) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack) |=> req_q);
  p_ack_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !req_q);
  p_no_new_req_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !req_q) |=> !req_q);
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hb && ie) |=> (cnt_q == '0));
  p_masked_hb_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ie && !ack && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_ctrl_regs.sv
module wdg_ctrl_regs
  import wdg_pkg::*;
#(
  parameter int   N_CORES = 4,
  parameter int   DATA_W  = 32,
  parameter logic EN_RST  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [REG_AW-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [N_CORES-1:0]   fire,
  output logic                 en,
  output logic [N_CORES-1:0]   status
);
  logic               en_q, en_d, ctrl_wr;
  logic               stclr_wr;
  logic [N_CORES-1:0] clr_mask;
  logic [N_CORES-1:0] stat_q, stat_d;

  assign ctrl_wr  = bus_we & (bus_addr == WDG_REG_CTRL);
  assign stclr_wr = bus_we & (bus_addr == WDG_REG_STCLR);
  assign clr_mask = stclr_wr ? bus_wdata[N_CORES-1:0] : '0;

  always_comb begin
    en_d = en_q;
    if (ctrl_wr) begin
      en_d = bus_wdata[0];
    end
  end

  always_comb begin
    stat_d = (stat_q & ~clr_mask) | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= EN_RST;
      stat_q <= '0;
    end else begin
      en_q   <= en_d;
      stat_q <= stat_d;
    end
  end

  assign en     = en_q;
  assign status = stat_q;

  p_en_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (en_q == $past(bus_wdata[0])));
  p_fire_sets_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire) |=> ((stat_q & $past(fire)) == $past(fire)));
  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stclr_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/hb_nmi_watchdog.sv
module hb_nmi_watchdog
  import wdg_pkg::*;
#(
  parameter int   N_CORES = 4,
  parameter int   TICK_HZ = 1000,
  parameter int   TIMEOUT = 5 * TICK_HZ,
  parameter int   DATA_W  = 32,
  parameter logic EN_RST  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [N_CORES-1:0]   hb_i,
  input  logic [N_CORES-1:0]   ie_i,
  input  logic [N_CORES-1:0]   nmi_ack_i,
  input  logic                 bus_we_i,
  input  logic [REG_AW-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [N_CORES-1:0]   nmi_req_o,
  output logic [N_CORES-1:0]   status_o
);
  logic               wd_en;
  logic [N_CORES-1:0] fire;

  wdg_ctrl_regs #(
    .N_CORES (N_CORES),
    .DATA_W  (DATA_W),
    .EN_RST  (EN_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .fire      (fire),
    .en        (wd_en),
    .status    (status_o)
  );

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    wdg_core_timer #(.TIMEOUT(TIMEOUT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (wd_en),
      .tick  (tick_i),
      .hb    (hb_i[g]),
      .ie    (ie_i[g]),
      .ack   (nmi_ack_i[g]),
      .req   (nmi_req_o[g]),
      .fire  (fire[g])
    );
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (nmi_req_o == '0));
  p_status_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((nmi_req_o & ~$past(nmi_req_o)) & ~status_o) == '0);
endmodule

// File: tb/test_hb_nmi_watchdog.sv
module test_hb_nmi_watchdog;
  localparam int N  = 4;
  localparam int TO = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick;
  logic [N-1:0]  hb, ie, ack;
  logic          we;
  logic [1:0]    addr;
  logic [DW-1:0] wdata;
  logic [N-1:0]  req, stat;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic         m_en;
  logic [N-1:0] m_req, m_stat;
  int           m_cnt [N];

  always #5 clk = ~clk;

  hb_nmi_watchdog #(.N_CORES(N), .TIMEOUT(TO), .DATA_W(DW)) i_hb_nmi_watchdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .hb_i        (hb),
    .ie_i        (ie),
    .nmi_ack_i   (ack),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .nmi_req_o   (req),
    .status_o    (stat)
  );

  task automatic check_eq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Expected next state from the requirements, one edge at a time.
  task automatic model_edge();
    logic [N-1:0] fire_v;
    logic [N-1:0] clr;
    for (int i = 0; i < N; i++) begin
      logic restart;
      restart   = (hb[i] & ie[i]) | ack[i];                     // R3, R5
      fire_v[i] = m_en && !restart && tick && !m_req[i] && (m_cnt[i] == TO - 1); // R2, R4
      if (!m_en || restart)        m_cnt[i] = 0;                // R6, R7
      else if (tick && !m_req[i])  m_cnt[i] = fire_v[i] ? 0 : m_cnt[i] + 1;
      if (ack[i])         m_req[i] = 1'b0;
      else if (fire_v[i]) m_req[i] = 1'b1;
    end
    clr    = (we && addr == 2'd1) ? wdata[N-1:0] : '0;
    m_stat = (m_stat & ~clr) | fire_v;                          // R8
    if (we && addr == 2'd0) m_en = wdata[0];
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    cyc++;
    model_edge();
    #1;
    check_eq(32'(req), 32'(m_req), tag);
    check_eq(32'(stat), 32'(m_stat), {tag, " status"});
  endtask

  task automatic idle_inputs();
    tick = 1'b0; hb = '0; ack = '0; we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d, input string tag);
    we = 1'b1; addr = a; wdata = d;
    step(tag);
    we = 1'b0;
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    idle_inputs();
    ie = '1;
    m_en = 1'b1; m_req = '0; m_stat = '0;
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check_eq(32'(req), 0, "R1 req in reset");
    check_eq(32'(stat), 0, "R1 status in reset");
    rst_n = 1'b1;
    step("R1");
    step("R1");

    // Masked heartbeats do not restart; all cores expire together.
    ie = '0; hb = '1; tick = 1'b1;
    for (int k = 1; k < TO; k++) step("R3 masked heartbeat");
    check_eq(32'(req), 0, "R2 no request one tick early");
    step("R4");
    check_eq(32'(req), 32'hF, "R9 simultaneous expiry");
    check_eq(32'(stat), 32'hF, "R8 status set");
    hb = '0;
    repeat (3) step("R5 held");
    check_eq(32'(req), 32'hF, "R5 request held without ack");

    // Acknowledge core 0 only.
    ack = 4'b0001;
    step("R5");
    ack = '0;
    check_eq(32'(req), 32'hE, "R10 ack leaves other cores");
    check_eq(32'(stat), 32'hF, "R8 status sticky after ack");
    tick = 1'b0;
    bus_write(2'd1, 32'h5, "R8 clear");
    check_eq(32'(stat), 32'hA, "R8 write-one clear");

    // Disable: no new requests, pending ones stay until acked.
    bus_write(2'd0, 32'h0, "R6 disable");
    tick = 1'b1;
    for (int k = 0; k < 3 * TO; k++) step("R6 disabled");
    check_eq(32'(req), 32'hE, "R6 pending kept, none new");
    ack = '1;
    step("R5");
    ack = '0;
    for (int k = 0; k < 2 * TO; k++) step("R6 disabled");
    check_eq(32'(req), 0, "R6 no request while disabled");

    // Re-enable: first request exactly TO edges later.
    bus_write(2'd0, 32'h1, "R7 enable");
    n = 0;
    while (req == '0 && n < 4 * TO) begin
      step("R7");
      n++;
    end
    check_eq(32'(n), 32'(TO), "R7 restart from zero");
    ack = '1;
    step("R5");
    ack = '0;

    // Serviced heartbeat on core 1 keeps it alive; others expire.
    ie = '1;
    for (int k = 0; k < 3 * TO; k++) begin
      hb = ((k % (TO - 1)) == TO - 2) ? 4'b0010 : '0;
      step("R3 serviced heartbeat");
      hb = '0;
    end
    check_eq(32'(req[1]), 0, "R10 serviced core never fires");
    check_eq(32'(req & 4'b1101), 32'hD, "R10 starved cores fire");
    ack = '1;
    step("R5");
    ack = '0;

    // Random traffic.
    for (int k = 0; k < 4000; k++) begin
      tick = ($urandom_range(1, 0) == 1);
      for (int i = 0; i < N; i++) begin
        hb[i]  = ($urandom_range(23, 0) == 0);
        ie[i]  = ($urandom_range(3, 0) != 0);
        ack[i] = req[i] && ($urandom_range(7, 0) == 0);
      end
      we = 1'b0; addr = '0; wdata = '0;
      if ($urandom_range(63, 0) == 0) begin
        we = 1'b1; addr = 2'd0; wdata = 32'($urandom_range(3, 0) != 0);
      end else if ($urandom_range(15, 0) == 0) begin
        we = 1'b1; addr = 2'd1; wdata = 32'($urandom_range(15, 0));
      end
      step("R2 random");
    end
    idle_inputs();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule